// File: doc/BRIEF.md
# Byte-Wide Processor Bus Cycle Sequencer

This block produces the local bus cycle of a processor core that has an 8-bit data bus and runs its own bus control. The core side asks for one transfer at a time. The kinds are a memory read, a memory write, an I/O read, an I/O write, or an interrupt acknowledge. The sequencer then steps through the bus states. These are an address state (T1), a command state (T2), a wait-decision state (T3), zero or more wait states (Tw) and a closing state (T4). Each state lasts two clocks, so strobes can change halfway through a state.

The low address byte and the data share one multiplexed byte lane. Its drive is modelled by an output enable rather than by a real tri-state pad. The upper address bits have their own outputs and stay latched for the whole cycle. An address-latch strobe, a memory/I-O select, read, write and acknowledge strobes, and a direction and an enable for an external bidirectional transceiver complete the bus side. A ready input from the addressed device stretches the cycle with wait states.

An interrupt acknowledge runs two acknowledge cycles back to back without returning to idle. The byte read in the second cycle is the interrupt type. It is returned multiplied by four as a 10-bit pointer into the vector table.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is asserted and afterwards until a request is accepted, the block is idle. In this state busy_o=0, ale_o=0, rd_n_o=wr_n_o=inta_n_o=den_n_o=1, dt_r_o=1, io_m_o=0, ad_oe_o=0, done_o=0 and vec_valid_o=0.
- R2: Request codes are 0 memory read, 1 memory write, 2 I/O read, 3 I/O write and 4 interrupt acknowledge. In T1, ale_o is high for both clocks. For codes 0-3, ad_o carries address bits [7:0] with ad_oe_o high. a_hi_o carries address bits [ADDR_W-1:8] from T1 until the next request with codes 0-3. io_m_o is high during codes 2, 3 and 4 and low during codes 0 and 1.
- R3: On a write, wr_n_o is low from the first clock of T2 through T3 and every Tw. The write byte is driven on ad_o with ad_oe_o high from T2 through the first clock of T4. dt_r_o is high.
- R4: On a read, rd_n_o goes low only at the second clock of T2 and stays low through T3 and every Tw. ad_oe_o is low whenever rd_n_o is low. dt_r_o is low for reads and acknowledges.
- R5: ready_i is sampled at the second clock of T3 and at the second clock of each Tw. Each low sample adds one two-clock Tw, and T4 follows the first high sample.
- R6: A read captures ad_i at the ready sample that ends the wait. done_o pulses for one clock at the first clock of the final T4, with rdata_o holding the captured byte. Writes leave rdata_o unchanged.
- R7: den_n_o is low only while data moves. For reads and acknowledges this is the same window as the read strobe. For writes it covers T2, T3, every Tw and the first clock of T4.
- R8: An acknowledge runs two cycles with no idle between them. In both cycles inta_n_o takes the timing of rd_n_o while rd_n_o stays high, ad_oe_o stays low in T1, and a_hi_o keeps the last address.
- R9: Only the byte sampled in the second acknowledge cycle is captured. vec_ptr_o equals that byte times four, zero-extended to 10 bits. vec_valid_o is a one-clock pulse coincident with done_o at the end of the second cycle.
- R10: A request is taken only while busy_o is low. Requests and changes on the request inputs during a cycle have no effect, and codes 5 to 7 start no cycle.
- R11: Every bus state lasts exactly two clocks. After the final T4 the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transfer request |
| req_kind_i | input | 3 | Transfer kind code |
| req_addr_i | input | ADDR_W | Transfer address |
| req_wdata_i | input | 8 | Byte to write |
| busy_o | output | 1 | A bus cycle is in progress |
| done_o | output | 1 | Transfer finished pulse |
| rdata_o | output | 8 | Last byte read from the bus |
| vec_valid_o | output | 1 | Vector pointer valid pulse |
| vec_ptr_o | output | 10 | Interrupt type times four |
| ready_i | input | 1 | Device ready, low inserts waits |
| ad_i | input | 8 | Byte lane input from the bus |
| ad_o | output | 8 | Byte lane output: address low byte or write data |
| ad_oe_o | output | 1 | Byte lane drive enable |
| a_hi_o | output | ADDR_W-8 | Latched upper address |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| inta_n_o | output | 1 | Interrupt acknowledge strobe, active low |
| io_m_o | output | 1 | High selects I/O space |
| dt_r_o | output | 1 | Transceiver direction, high transmits |
| den_n_o | output | 1 | Transceiver enable, active low |

## Verification
The bench sweeps all five kinds against zero to three wait states. It compares every clock of every cycle against a timeline computed from the state index, so a read strobe that starts early in T2 shows up as a mismatch, as does a write strobe that starts late or write data dropped before T4. The acknowledge pair drives a decoy byte in its first cycle and uses a different wait count in each cycle. A design that captured the first byte, split the pair with an idle state, or moved the upper address would report a wrong pointer or a wrong timeline. Requests held high with altered code and address during a cycle, and undefined codes offered while idle, would expose a design that restarts or accepts them. A write that disturbed rdata_o is caught at its done pulse.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = BYTE_W + 2;

  typedef enum logic [2:0] {
    K_MEM_RD = 3'd0,
    K_MEM_WR = 3'd1,
    K_IO_RD  = 3'd2,
    K_IO_WR  = 3'd3,
    K_INTA   = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4
  } tstate_e;
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BYTE_W-1:0] req_wdata_i,
  input  logic              ready_i,
  output tstate_e           st_o,
  output logic              ph_o,
  output kind_e             kind_o,
  output logic              second_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              sample_o,
  output logic              busy_o,
  output logic              done_o
);
  tstate_e           st_q;
  logic              ph_q;
  kind_e             kind_q;
  logic              second_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  kind_e             req_kind;
  logic              accept;

  assign req_kind = kind_e'(req_kind_i);
  assign accept   = req_i && (st_q == ST_IDLE) && (req_kind_i <= 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ph_q     <= 1'b0;
      kind_q   <= K_MEM_RD;
      second_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (st_q == ST_IDLE) begin
      ph_q <= 1'b0;
      if (accept) begin
        st_q     <= ST_T1;
        kind_q   <= req_kind;
        second_q <= 1'b0;
        wdata_q  <= req_wdata_i;
        // acknowledge keeps the previous address on the bus
        if (req_kind != K_INTA) addr_q <= req_addr_i;
      end
    end else begin
      ph_q <= ~ph_q;
      if (ph_q) begin
        unique case (st_q)
          ST_T1:        st_q <= ST_T2;
          ST_T2:        st_q <= ST_T3;
          ST_T3, ST_TW: st_q <= ready_i ? ST_T4 : ST_TW;
          ST_T4: begin
            if (kind_q == K_INTA && !second_q) begin
              st_q     <= ST_T1;
              second_q <= 1'b1;
            end else begin
              st_q <= ST_IDLE;
            end
          end
          default:      st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign st_o     = st_q;
  assign ph_o     = ph_q;
  assign kind_o   = kind_q;
  assign second_o = second_q;
  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign sample_o = ph_q && (st_q == ST_T3 || st_q == ST_TW);
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = (st_q == ST_T4) && !ph_q && (kind_q != K_INTA || second_q);

  // R5
  wait_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && !ready_i) |=> (st_q == ST_TW && !ph_q));
  // R5
  close_on_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && ready_i) |=> (st_q == ST_T4 && !ph_q));
  // R10
  bad_code_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && req_kind_i > 3'd4) |=> !busy_o);
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  state_two_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ph_q) |=> (st_q == $past(st_q) && ph_q));
endmodule

// File: rtl/bus_seq_strobe.sv
module bus_seq_strobe
  import bus_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tstate_e           st_i,
  input  logic              ph_i,
  input  kind_e             kind_i,
  input  logic [BYTE_W-1:0] addr_lo_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              inta_n_o,
  output logic              io_m_o,
  output logic              dt_r_o,
  output logic              den_n_o,
  output logic              ad_oe_o,
  output logic [BYTE_W-1:0] ad_o
);
  logic is_wr, is_rd, is_ia, active;
  logic in_t1, in_t2, mid, t4_early, rd_win, wr_win;

  always_comb begin
    is_wr    = (kind_i == K_MEM_WR) || (kind_i == K_IO_WR);
    is_rd    = (kind_i == K_MEM_RD) || (kind_i == K_IO_RD);
    is_ia    = (kind_i == K_INTA);
    active   = (st_i != ST_IDLE);
    in_t1    = (st_i == ST_T1);
    in_t2    = (st_i == ST_T2);
    mid      = (st_i == ST_T3) || (st_i == ST_TW);
    t4_early = (st_i == ST_T4) && !ph_i;
    // read side waits half a state so the lane drivers are off first
    rd_win   = (in_t2 && ph_i) || mid;
    wr_win   = in_t2 || mid;

    ale_o    = in_t1;
    rd_n_o   = !(is_rd && rd_win);
    inta_n_o = !(is_ia && rd_win);
    wr_n_o   = !(is_wr && wr_win);
    den_n_o  = is_wr ? !(wr_win || t4_early) : !rd_win;
    dt_r_o   = active ? is_wr : 1'b1;
    io_m_o   = active && (kind_i == K_IO_RD || kind_i == K_IO_WR || is_ia);
    ad_oe_o  = (in_t1 && !is_ia) || (is_wr && (wr_win || t4_early));
    ad_o     = in_t1 ? addr_lo_i : wdata_i;
  end

  // R4
  no_contend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !inta_n_o) |-> !ad_oe_o);
  // R3
  wr_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> (ad_oe_o && !den_n_o && dt_r_o));
  // R2
  ale_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_n_o && wr_n_o && inta_n_o));
  // R8
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~rd_n_o, ~wr_n_o, ~inta_n_o}) <= 1);
endmodule

// File: rtl/bus_seq_capture.sv
module bus_seq_capture
  import bus_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              ready_i,
  input  logic              take_i,
  input  logic              done_i,
  input  logic              is_inta_i,
  input  logic [BYTE_W-1:0] ad_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              vec_valid_o,
  output logic [PTR_W-1:0]  vec_ptr_o
);
  logic [BYTE_W-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byte_q <= '0;
    else if (sample_i && ready_i && take_i) byte_q <= ad_i;
  end

  assign rdata_o     = byte_q;
  assign vec_valid_o = done_i && is_inta_i;
  assign vec_ptr_o   = {byte_q, 2'b00};

  // R9
  vec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o);
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_i && ready_i && take_i) |=> $stable(byte_q));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [2:0]          req_kind_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [7:0]          req_wdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [7:0]          rdata_o,
  output logic                vec_valid_o,
  output logic [9:0]          vec_ptr_o,
  input  logic                ready_i,
  input  logic [7:0]          ad_i,
  output logic [7:0]          ad_o,
  output logic                ad_oe_o,
  output logic [ADDR_W-9:0]   a_hi_o,
  output logic                ale_o,
  output logic                rd_n_o,
  output logic                wr_n_o,
  output logic                inta_n_o,
  output logic                io_m_o,
  output logic                dt_r_o,
  output logic                den_n_o
);
  tstate_e           st;
  logic              ph, second, sample, take;
  kind_e             kind;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] wdata;

  bus_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .req_i, .req_kind_i, .req_addr_i, .req_wdata_i, .ready_i,
    .st_o(st), .ph_o(ph), .kind_o(kind), .second_o(second), .addr_o(addr),
    .wdata_o(wdata), .sample_o(sample), .busy_o, .done_o
  );

  bus_seq_strobe u_strobe (
    .clk_i, .rst_ni, .st_i(st), .ph_i(ph), .kind_i(kind),
    .addr_lo_i(addr[BYTE_W-1:0]), .wdata_i(wdata),
    .ale_o, .rd_n_o, .wr_n_o, .inta_n_o, .io_m_o, .dt_r_o, .den_n_o,
    .ad_oe_o, .ad_o
  );

  // first acknowledge cycle reads nothing
  assign take = (kind == K_MEM_RD) || (kind == K_IO_RD) || (kind == K_INTA && second);

  bus_seq_capture u_cap (
    .clk_i, .rst_ni, .sample_i(sample), .ready_i, .take_i(take), .done_i(done_o),
    .is_inta_i(kind == K_INTA), .ad_i, .rdata_o, .vec_valid_o, .vec_ptr_o
  );

  assign a_hi_o = addr[ADDR_W-1:BYTE_W];

  // R8
  inta_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inta_n_o || (busy_o && kind == K_INTA)) |=> $stable(a_hi_o) || !busy_o);
endmodule

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;
  localparam int AW = 20;
  localparam int HW = AW - 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [2:0]    req_kind_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [7:0]    req_wdata_i = '0;
  logic          ready_i = 1'b0;
  logic [7:0]    ad_i = '0;
  logic          busy_o, done_o, vec_valid_o, ad_oe_o, ale_o;
  logic          rd_n_o, wr_n_o, inta_n_o, io_m_o, dt_r_o, den_n_o;
  logic [7:0]    rdata_o, ad_o;
  logic [9:0]    vec_ptr_o;
  logic [HW-1:0] a_hi_o;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] last_addr = '0;
  logic [7:0]    last_rd = '0;

  always #10 clk = ~clk;

  bus_cycle_seq #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni, .req_i, .req_kind_i, .req_addr_i, .req_wdata_i,
    .busy_o, .done_o, .rdata_o, .vec_valid_o, .vec_ptr_o, .ready_i, .ad_i,
    .ad_o, .ad_oe_o, .a_hi_o, .ale_o, .rd_n_o, .wr_n_o, .inta_n_o, .io_m_o,
    .dt_r_o, .den_n_o
  );

  function automatic logic [63:0] act_vec();
    return {15'b0, ale_o, rd_n_o, wr_n_o, inta_n_o, den_n_o, dt_r_o, io_m_o,
            ad_oe_o, busy_o, done_o, vec_valid_o,
            (ad_oe_o ? ad_o : 8'h00), a_hi_o,
            (done_o ? rdata_o : 8'h00), (vec_valid_o ? vec_ptr_o : 10'h000)};
  endfunction

  function automatic logic [63:0] idle_vec(logic [HW-1:0] hi);
    return {15'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
            8'h00, hi, 8'h00, 10'h000};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic run_txn(int kind, int w, int p, bit hold);
    logic [AW-1:0] addr;
    logic [7:0] wd, dv;
    int nsub;
    bit isw, isr, isi, io;
    addr = AW'((kind * 4 + w + 1) * 32'h1357 + p * 32'h8421);
    wd   = 8'hA5 ^ 8'(kind << 4) ^ 8'(w) ^ 8'(p * 8'h3C);
    dv   = 8'h5A + 8'(kind * 17) + 8'(w * 3) + 8'(p * 8'h40);
    isw  = (kind == 1 || kind == 3);
    isr  = (kind == 0 || kind == 2);
    isi  = (kind == 4);
    io   = (kind >= 2);
    nsub = isi ? 2 : 1;
    @(negedge clk);
    req_i = 1'b1; req_kind_i = 3'(kind); req_addr_i = addr; req_wdata_i = wd;
    for (int sub = 0; sub < nsub; sub++) begin
      int ww, len;
      logic [7:0] bv;
      ww  = (sub == 1) ? (w + 1) % 3 : w;
      len = 8 + 2 * ww;
      bv  = (isi && sub == 0) ? ~dv : dv;  // decoy in the first acknowledge
      for (int j = 0; j < len; j++) begin
        bit t1, t2, mid, tw, t4, ph, rdw, wrw, t4e;
        logic e_oe, e_done, e_vv;
        logic [7:0] e_ad, e_rd;
        logic [9:0] e_vp;
        logic [HW-1:0] e_hi;
        logic [63:0] exp;
        string tag;
        @(negedge clk);
        // R10: request held with altered code and address during the cycle
        if (!hold) req_i = 1'b0;
        else begin
          req_i = !(sub == nsub - 1 && j == len - 1);
          req_kind_i = 3'd3;
          req_addr_i = ~addr;
        end
        ready_i = (j >= 5 + 2 * ww);
        ad_i    = bv;
        t1  = (j < 2);
        t2  = (j >= 2 && j < 4);
        mid = (j >= 4 && j < 6 + 2 * ww);
        tw  = (j >= 6 && mid);
        t4  = (j >= 6 + 2 * ww);
        ph  = (j % 2) == 1;
        rdw = (t2 && ph) || mid;
        wrw = t2 || mid;
        t4e = t4 && !ph;
        e_oe   = (t1 && !isi) || (isw && (wrw || t4e));
        e_done = t4e && (!isi || sub == 1);
        e_vv   = e_done && isi;
        e_ad   = e_oe ? (t1 ? addr[7:0] : wd) : 8'h00;
        e_hi   = isi ? last_addr[AW-1:8] : addr[AW-1:8];
        e_rd   = e_done ? (isw ? last_rd : dv) : 8'h00;
        e_vp   = e_vv ? {dv, 2'b00} : 10'h000;
        exp = {15'b0, t1, !(isr && rdw), !(isw && wrw), !(isi && rdw),
               (isw ? !(wrw || t4e) : !rdw), isw, io, e_oe, 1'b1, e_done, e_vv,
               e_ad, e_hi, e_rd, e_vp};
        if (e_vv)        tag = "R9";
        else if (e_done) tag = "R6";
        else if (tw)     tag = "R5";
        else if (t1)     tag = "R2 R11";
        else if (isi)    tag = "R8";
        else if (isw)    tag = "R3 R7";
        else             tag = "R4 R7";
        if (hold) tag = {tag, " R10"};
        chk(tag, act_vec(), exp);
      end
    end
    req_i = 1'b0;
    if (!isi) last_addr = addr;
    if (!isw) last_rd = dv;
    @(negedge clk);
    chk("R11 idle after T4", act_vec(), idle_vec(last_addr[AW-1:8]));
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", act_vec(), idle_vec('0));
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset", act_vec(), idle_vec('0));
    // R10: undefined codes start nothing
    for (int c = 5; c < 8; c++) begin
      req_i = 1'b1; req_kind_i = 3'(c); req_addr_i = 20'hFFFFF;
      @(negedge clk);
      req_i = 1'b0;
      chk("R10 bad code", act_vec(), idle_vec('0));
    end
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 5; k++)
        for (int w = 0; w < 4; w++)
          run_txn(k, w, p, (p == 1) && (w == 2));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule